// File: doc/BRIEF.md
# System Power Mode Controller

This block sequences a small microcontroller through its six power modes: normal run, wait, stop, very-low-power run, very-low-power wait and very-low-power stop. It takes a software run-mode write, the core's sleep and deep-sleep requests, a wakeup event and one stop acknowledge per peripheral. It drives the enables for the core, system, bus and flash clocks, a regulator select, a low-frequency flag, a stop request to the peripherals and a 3-bit code for the current mode.

Stop-class entry is a handshake. The core clock is gated at once and the stop request is raised. The system, bus and flash clocks stay on until every peripheral acknowledges. A wakeup during this wait cancels the entry. On the way back out of a stop-class mode, the system, bus and flash clocks return one cycle before the core clock. The low-power wait and stop modes can only be reached from the restricted-frequency run mode.

Top module: `pmc_mode_ctrl`

## Requirements
- R1: After reset the mode is RUN, the core, system, bus and flash clock enables are all 1, run regulation is selected (`stop_reg_sel_o`=0), `low_freq_o`=0 and `stop_req_o`=0.
- R2: `mode_o` reports the current mode with RUN=0, WAIT=1, STOP=2, VLPR=3, VLPW=4, VLPS=5. A stop entry that is waiting for acknowledges, or a wake that is restoring clocks, reports the stop-class code (2 or 5).
- R3: In RUN, a cycle with `rm_wr_i`=1 and `rm_lp_i`=1 gives VLPR on the next cycle. In VLPR, a cycle with `rm_wr_i`=1 and `rm_lp_i`=0 gives RUN on the next cycle.
- R4: From RUN, `sleep_req_i` enters WAIT and `deep_sleep_req_i` starts a STOP entry. From VLPR, the same requests enter VLPW and start a VLPS entry. When several are asserted together, deep sleep wins over sleep, and sleep wins over a run-mode write. VLPW and VLPS are entered only from VLPR.
- R5: A run-mode write in any mode other than RUN or VLPR leaves the mode and all outputs unchanged. A write of `rm_lp_i`=0 in RUN, or of `rm_lp_i`=1 in VLPR, also changes nothing.
- R6: In WAIT and VLPW the core clock enable is 0, and the system, bus and flash enables stay 1.
- R7: During a stop entry, `stop_req_o`=1 and the core enable is 0 while the other enables stay 1. In the cycle after a cycle in which all `stop_ack_i` bits are 1, the system, bus and flash enables drop to 0.
- R8: While any `stop_ack_i` bit is 0, the system, bus and flash clocks are not gated.
- R9: A wakeup during a stop entry withdraws `stop_req_o` and restores the core clock on the next cycle, returning to RUN (or to VLPR for a VLPS entry). No other clock is gated. The wakeup takes priority over acknowledges that arrive in the same cycle.
- R10: A wakeup in STOP or VLPS gives one cycle in which the system, bus and flash enables are 1, the core enable is 0 and `stop_req_o`=0. The next cycle is RUN (or VLPR) with the core enabled.
- R11: `stop_reg_sel_o` and `low_freq_o` are 1 exactly when the mode code is 3, 4 or 5.
- R12: A wakeup in WAIT gives RUN on the next cycle. A wakeup in VLPW gives VLPR on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rm_wr_i | input | 1 | Run-mode field write strobe |
| rm_lp_i | input | 1 | Run-mode value written: 1 selects restricted-frequency run |
| sleep_req_i | input | 1 | Core sleep request |
| deep_sleep_req_i | input | 1 | Core deep-sleep request |
| wake_i | input | 1 | Wakeup event |
| stop_ack_i | input | N_PERIPH | Per-peripheral stop acknowledge |
| mode_o | output | 3 | Current mode code |
| core_clk_en_o | output | 1 | Core clock enable |
| sys_clk_en_o | output | 1 | System clock enable |
| bus_clk_en_o | output | 1 | Bus clock enable |
| flash_clk_en_o | output | 1 | Flash clock enable |
| stop_reg_sel_o | output | 1 | 1 selects stop-mode regulation |
| low_freq_o | output | 1 | Restricted bus frequency flag |
| stop_req_o | output | 1 | Stop request to peripherals |

## Verification
The assertions check on every cycle that:
- the system clock falls only in the cycle after a full acknowledge;
- the core clock is never on while the bus clock is off;
- the core clock returns only after the bus clock was already on;
- a low-power wait or stop is entered only from VLPR;
- the regulator select follows the mode code.

Only the bench's scenarios can show the rest:
- the exact next mode for each request;
- the priority among requests that arrive together;
- that writes in the wrong mode are ignored;
- the abort of a stop entry that is waiting on partial acknowledges.

The bench covers these with a behavioural model compared on every clock.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    MODE_RUN  = 3'd0,
    MODE_WAIT = 3'd1,
    MODE_STOP = 3'd2,
    MODE_VLPR = 3'd3,
    MODE_VLPW = 3'd4,
    MODE_VLPS = 3'd5
  } pmc_mode_e;

  typedef enum logic [3:0] {
    ST_RUN, ST_WAIT, ST_STOP_PEND, ST_STOP, ST_STOP_WAKE,
    ST_VLPR, ST_VLPW, ST_VLPS_PEND, ST_VLPS, ST_VLPS_WAKE
  } pmc_state_e;

  typedef struct packed {
    logic core;
    logic sys;
    logic bus;
    logic flash;
  } pmc_clk_en_t;
endpackage

// File: rtl/pmc_ack_gather.sv
module pmc_ack_gather #(
  parameter int N_PERIPH = 4
) (
  input  logic [N_PERIPH-1:0] ack_i,
  output logic                all_ack_o
);
  logic [N_PERIPH:0] chain;
  assign chain[0] = 1'b1;
  for (genvar i = 0; i < N_PERIPH; i++) begin : g_and
    assign chain[i+1] = chain[i] & ack_i[i];
  end
  assign all_ack_o = chain[N_PERIPH];
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rm_wr_i,
  input  logic       rm_lp_i,
  input  logic       sleep_i,
  input  logic       deep_i,
  input  logic       wake_i,
  input  logic       all_ack_i,
  output pmc_state_e state_o
);
  pmc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (deep_i)                   state_d = ST_STOP_PEND;
        else if (sleep_i)             state_d = ST_WAIT;
        else if (rm_wr_i && rm_lp_i)  state_d = ST_VLPR;
      end
      ST_WAIT:      if (wake_i) state_d = ST_RUN;
      ST_STOP_PEND: begin
        if (wake_i)         state_d = ST_RUN;  // abort wins over late acks
        else if (all_ack_i) state_d = ST_STOP;
      end
      ST_STOP:      if (wake_i) state_d = ST_STOP_WAKE;
      ST_STOP_WAKE: state_d = ST_RUN;
      ST_VLPR: begin
        if (deep_i)                   state_d = ST_VLPS_PEND;
        else if (sleep_i)             state_d = ST_VLPW;
        else if (rm_wr_i && !rm_lp_i) state_d = ST_RUN;
      end
      ST_VLPW:      if (wake_i) state_d = ST_VLPR;
      ST_VLPS_PEND: begin
        if (wake_i)         state_d = ST_VLPR;
        else if (all_ack_i) state_d = ST_VLPS;
      end
      ST_VLPS:      if (wake_i) state_d = ST_VLPS_WAKE;
      ST_VLPS_WAKE: state_d = ST_VLPR;
      default:      state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  p_pend_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_STOP_PEND || state_q == ST_VLPS_PEND) && wake_i)
      |=> (state_q == ST_RUN || state_q == ST_VLPR));
endmodule

// File: rtl/pmc_out_decode.sv
module pmc_out_decode
  import pmc_pkg::*;
(
  input  pmc_state_e  state_i,
  output pmc_mode_e   mode_o,
  output pmc_clk_en_t clk_en_o,
  output logic        stop_req_o,
  output logic        vlp_o
);
  always_comb begin
    mode_o     = MODE_RUN;
    clk_en_o   = '{core: 1'b0, sys: 1'b1, bus: 1'b1, flash: 1'b1};
    stop_req_o = 1'b0;
    unique case (state_i)
      ST_RUN:       begin mode_o = MODE_RUN;  clk_en_o.core = 1'b1; end
      ST_WAIT:      mode_o = MODE_WAIT;
      ST_STOP_PEND: begin mode_o = MODE_STOP; stop_req_o = 1'b1; end
      ST_STOP:      begin mode_o = MODE_STOP; stop_req_o = 1'b1; clk_en_o = '0; end
      ST_STOP_WAKE: mode_o = MODE_STOP;
      ST_VLPR:      begin mode_o = MODE_VLPR; clk_en_o.core = 1'b1; end
      ST_VLPW:      mode_o = MODE_VLPW;
      ST_VLPS_PEND: begin mode_o = MODE_VLPS; stop_req_o = 1'b1; end
      ST_VLPS:      begin mode_o = MODE_VLPS; stop_req_o = 1'b1; clk_en_o = '0; end
      ST_VLPS_WAKE: mode_o = MODE_VLPS;
      default:      begin mode_o = MODE_RUN;  clk_en_o.core = 1'b1; end
    endcase
  end

  assign vlp_o = (state_i inside {ST_VLPR, ST_VLPW, ST_VLPS_PEND, ST_VLPS, ST_VLPS_WAKE});
endmodule

// File: rtl/pmc_mode_ctrl.sv
module pmc_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int N_PERIPH = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rm_wr_i,
  input  logic                rm_lp_i,
  input  logic                sleep_req_i,
  input  logic                deep_sleep_req_i,
  input  logic                wake_i,
  input  logic [N_PERIPH-1:0] stop_ack_i,
  output logic [2:0]          mode_o,
  output logic                core_clk_en_o,
  output logic                sys_clk_en_o,
  output logic                bus_clk_en_o,
  output logic                flash_clk_en_o,
  output logic                stop_reg_sel_o,
  output logic                low_freq_o,
  output logic                stop_req_o
);
  logic        all_ack;
  pmc_state_e  state;
  pmc_mode_e   mode;
  pmc_clk_en_t clk_en;
  logic        vlp;

  pmc_ack_gather #(.N_PERIPH(N_PERIPH)) u_ack (
    .ack_i(stop_ack_i), .all_ack_o(all_ack)
  );

  pmc_mode_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .rm_wr_i(rm_wr_i), .rm_lp_i(rm_lp_i),
    .sleep_i(sleep_req_i), .deep_i(deep_sleep_req_i), .wake_i(wake_i),
    .all_ack_i(all_ack), .state_o(state)
  );

  pmc_out_decode u_dec (
    .state_i(state), .mode_o(mode), .clk_en_o(clk_en),
    .stop_req_o(stop_req_o), .vlp_o(vlp)
  );

  assign mode_o         = mode;
  assign core_clk_en_o  = clk_en.core;
  assign sys_clk_en_o   = clk_en.sys;
  assign bus_clk_en_o   = clk_en.bus;
  assign flash_clk_en_o = clk_en.flash;
  assign stop_reg_sel_o = vlp;
  assign low_freq_o     = vlp;

  p_gate_after_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_clk_en_o) |-> $past(&stop_ack_i));
  p_core_needs_bus_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_clk_en_o |-> !core_clk_en_o);
  p_core_after_bus_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_clk_en_o) |-> $past(sys_clk_en_o));
  p_vlp_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == 3'd4 || mode_o == 3'd5) && !$stable(mode_o)) |-> $past(mode_o) == 3'd3);
  p_reg_sel_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_reg_sel_o == (mode_o >= 3'd3));
endmodule

// File: tb/sim_pmc_mode_ctrl.sv
module sim_pmc_mode_ctrl;
  localparam int NP = 4;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr = 0, lp = 0, slp = 0, dslp = 0, wake = 0;
  logic [NP-1:0] ack = '0;
  logic [2:0] mode;
  logic core, sys, bus, flash, sreg, lowf, sreq;
  int checks = 0, errors = 0;
  int m = 0, ph = 0;  // model: mode code, phase 0 settled / 1 pending / 2 waking

  always #5 clk = ~clk;

  pmc_mode_ctrl #(.N_PERIPH(NP)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .rm_wr_i(wr), .rm_lp_i(lp),
    .sleep_req_i(slp), .deep_sleep_req_i(dslp), .wake_i(wake), .stop_ack_i(ack),
    .mode_o(mode), .core_clk_en_o(core), .sys_clk_en_o(sys), .bus_clk_en_o(bus),
    .flash_clk_en_o(flash), .stop_reg_sel_o(sreg), .low_freq_o(lowf), .stop_req_o(sreq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d mode=%0d ph=%0d t=%0t", tag, act, exp, m, ph, $time);
    end
  endtask

  task automatic model_step();
    bit full = &ack;
    case (m)
      0: if (dslp) begin m = 2; ph = 1; end
         else if (slp) m = 1;
         else if (wr && lp) m = 3;
      1: if (wake) m = 0;
      3: if (dslp) begin m = 5; ph = 1; end
         else if (slp) m = 4;
         else if (wr && !lp) m = 0;
      4: if (wake) m = 3;
      default: begin  // 2 or 5
        if (ph == 1) begin
          if (wake) begin m = m - 2; ph = 0; end
          else if (full) ph = 0;
        end else if (ph == 0) begin
          if (wake) ph = 2;
        end else begin
          m = m - 2; ph = 0;
        end
      end
    endcase
  endtask

  task automatic compare();
    bit stopc = (m == 2 || m == 5);
    int e_core = (ph == 0 && (m == 0 || m == 3)) ? 1 : 0;
    int e_bus  = (ph == 0 && stopc) ? 0 : 1;
    int e_req  = (ph == 1 || (ph == 0 && stopc)) ? 1 : 0;
    int e_vlp  = (m >= 3) ? 1 : 0;
    chk("R2 mode", mode, m);
    chk("R6/R9/R10 core_en", core, e_core);
    chk("R7/R8 sys_en", sys, e_bus);
    chk("R7/R8 bus_en", bus, e_bus);
    chk("R7 flash_en", flash, e_bus);
    chk("R7/R9 stop_req", sreq, e_req);
    chk("R11 stop_reg", sreg, e_vlp);
    chk("R11 low_freq", lowf, e_vlp);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    {wr, lp, slp, dslp, wake} = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #12;
    // R1 reset state
    chk("R1 mode", mode, 0); chk("R1 core", core, 1); chk("R1 sys", sys, 1);
    chk("R1 bus", bus, 1); chk("R1 flash", flash, 1); chk("R1 reg", sreg, 0);
    chk("R1 lowf", lowf, 0); chk("R1 req", sreq, 0);
    @(negedge clk); rst_ni = 1'b1;
    idle(2);
    // R5 write lp=0 in RUN no effect; R3 enter VLPR
    wr = 1; lp = 0; cyc();
    wr = 1; lp = 1; cyc();
    chk("R3 vlpr", mode, 3);
    wr = 1; lp = 1; cyc();  // R5 no-op in VLPR
    wr = 1; lp = 0; cyc();
    chk("R3 back run", mode, 0);
    // R4/R12 WAIT, R5 write ignored in WAIT
    slp = 1; cyc();
    chk("R6 wait core off", core, 0);
    wr = 1; lp = 1; cyc();
    chk("R5 wait ignore", mode, 1);
    wake = 1; cyc();
    chk("R12 wait wake", mode, 0);
    // R4 priority: deep beats sleep and write
    dslp = 1; slp = 1; wr = 1; lp = 1; cyc();
    chk("R4 deep prio", mode, 2);
    // R8 partial acks
    ack = 4'b0111; idle(3);
    wr = 1; lp = 1; cyc();
    chk("R5 pend ignore", mode, 2);
    ack = 4'b1111; cyc();
    chk("R7 gated", sys, 0);
    ack = 4'b1111; wr = 1; lp = 1; cyc();
    chk("R5 stop ignore", mode, 2);
    wake = 1; cyc();
    chk("R10 wake bus", sys, 1); chk("R10 wake core", core, 0);
    ack = '0; cyc();
    chk("R10 run core", core, 1);
    // R9 abort with simultaneous ack
    dslp = 1; cyc();
    ack = 4'b1011; idle(2);
    ack = 4'b1111; wake = 1; cyc();
    chk("R9 abort", mode, 0); chk("R9 abort req", sreq, 0);
    ack = '0;
    // VLP side
    wr = 1; lp = 1; cyc();
    slp = 1; slp = 1; wr = 1; lp = 0; cyc();
    chk("R4 sleep beats write", mode, 4);
    wr = 1; lp = 0; cyc();
    chk("R5 vlpw ignore", mode, 4);
    wake = 1; cyc();
    chk("R12 vlpw wake", mode, 3);
    dslp = 1; cyc();
    ack = 4'b1101; cyc();
    wake = 1; cyc();
    chk("R9 vlps abort", mode, 3);
    dslp = 1; cyc();
    ack = 4'b1111; cyc();
    chk("R7 vlps gated", bus, 0);
    idle(2);
    wake = 1; cyc();
    ack = '0; cyc();
    chk("R10 vlpr back", mode, 3);
    wr = 1; lp = 0; cyc();
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      wr = (r < 15); lp = $urandom_range(0, 1) != 0;
      slp = (r >= 15 && r < 22); dslp = (r >= 22 && r < 28);
      wake = ($urandom_range(0, 99) < 12);
      ack = NP'($urandom_range(0, (1 << NP) - 1));
      if ($urandom_range(0, 3) == 0) ack = '1;
      @(posedge clk); model_step(); @(negedge clk); compare();
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule